// File: doc/BRIEF.md
# I2C Channel Control Register

This block is the 16-bit control word for one I2C channel. It is placed between a simple CPU register bus and the I2C protocol engine. It holds two configuration bits: the master/slave select and the module enable. It also holds four command bits that software sets by writing 1: START, STOP, NACK and software reset.

Each command bit raises a level request toward the engine. The bit reads back as 1 while the request is outstanding. It clears itself only when its own completion event arrives: a done pulse from the engine for START, STOP and NACK, or the end of a fixed-length sequence for the software reset.

Two reset classes exist. The asynchronous hardware reset zeroes every bit. The software reset runs for a fixed number of cycles and drives a reset strobe to the engine and the interrupt-flag logic. It discards pending START, STOP and NACK requests but leaves the mode and enable bits as they are. Bus signalling and bus timing belong to the engine; this block only sees the engine's handshake.

Top module: `i2c_ctl_reg`

## Requirements
- R1: Read bits 15 to 6 are always 0, whatever value was written.
- R2: After hardware reset (rst_ni low) every read bit and every output is 0.
- R3: Writing 1 to bit 2 sets the START pending bit. It stays 1 until a cycle with start_done_i high, and clears at that clock edge.
- R4: Writing 1 to bit 3 sets the STOP pending bit. It stays 1 until a cycle with stop_done_i high, which the engine raises once the bus free time after the STOP has elapsed.
- R5: A write of 1 to bit 2 or bit 3 is ignored unless the same write also carries 1 in bit 5, the master mode bit.
- R6: Writing 1 to bit 4 sets the NACK pending bit in either mode. It clears on a cycle with nack_done_i high.
- R7: Writing 0 to bits 4, 3, 2 or 1 leaves those bits unchanged. Bits 5 (mode, 1 = master) and 0 (enable) take the written value.
- R8: Writing 1 to bit 1 starts a software reset. Bit 1 and srst_o read 1 for exactly SRST_CYCLES cycles starting at the next edge, then return to 0. A further write of 1 to bit 1 during the sequence does not extend it.
- R9: While the software reset runs, the START, STOP and NACK bits are cleared, and a write that sets them is discarded. Bits 5 and 0 keep their values unless they are written.
- R10: A done pulse that arrives while its command bit is 0 has no effect.
- R11: A write that sets a command bit in the same cycle as that bit's done pulse leaves the bit set.
- R12: start_req_o, stop_req_o and nack_req_o equal read bits 2, 3 and 4. master_o and enable_o equal bits 5 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous hardware reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read-back of the register |
| master_o | output | 1 | Mode select, 1 = master |
| enable_o | output | 1 | Module enable |
| start_req_o | output | 1 | START request level |
| stop_req_o | output | 1 | STOP request level |
| nack_req_o | output | 1 | NACK request level |
| start_done_i | input | 1 | START generated, one-cycle pulse |
| stop_done_i | input | 1 | STOP generated and bus free time elapsed, one-cycle pulse |
| nack_done_i | input | 1 | NACK sent, one-cycle pulse |
| srst_o | output | 1 | Software reset strobe to engine and interrupt flags |

## Verification
The bench uses the default build: DATA_W of 16 and SRST_CYCLES of 4. With only six live bits, every low-byte write pattern can be applied, each combined with every done-pulse pattern and both reserved-bit fillings. The collisions follow from that sweep: write against done, write against a running software reset, and mode gating within the same write. A reset sequence of 4 cycles also keeps the overlap between a sequence and the next writes short enough to sweep across all of its phases.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
  localparam int BIT_EN    = 0;
  localparam int BIT_SRST  = 1;
  localparam int BIT_START = 2;
  localparam int BIT_STOP  = 3;
  localparam int BIT_NACK  = 4;
  localparam int BIT_MODE  = 5;
  localparam int LIVE_BITS = 6;

  // command flag slots
  localparam int NUM_CMD  = 3;
  localparam int CMD_START = 0;
  localparam int CMD_STOP  = 1;
  localparam int CMD_NACK  = 2;
endpackage

// File: rtl/i2c_cmd_flag.sv
module i2c_cmd_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic done_i,
  input  logic flush_i,
  output logic pend_o
);
  logic pend_q;

  // flush beats set; set beats done
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (flush_i) pend_q <= 1'b0;
    else if (set_i)   pend_q <= 1'b1;
    else if (done_i)  pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/i2c_srst_seq.sv
module i2c_srst_seq #(
  parameter int CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic busy_o
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (kick_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/i2c_ctl_reg.sv
module i2c_ctl_reg
  import i2c_ctl_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SRST_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              master_o,
  output logic              enable_o,
  output logic              start_req_o,
  output logic              stop_req_o,
  output logic              nack_req_o,
  input  logic              start_done_i,
  input  logic              stop_done_i,
  input  logic              nack_done_i,
  output logic              srst_o
);
  localparam logic [NUM_CMD-1:0] MODE_GATED = 3'b011;

  logic mode_q, en_q;
  logic srst_busy;
  logic wr_master;
  logic [NUM_CMD-1:0] cmd_wbit, cmd_set, cmd_done, cmd_pend;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:LIVE_BITS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      en_q   <= 1'b0;
    end else if (wr_en_i) begin
      mode_q <= wdata_i[BIT_MODE];
      en_q   <= wdata_i[BIT_EN];
    end
  end

  // gating uses the mode carried by the same write
  assign wr_master = wdata_i[BIT_MODE];

  assign cmd_wbit[CMD_START] = wdata_i[BIT_START];
  assign cmd_wbit[CMD_STOP]  = wdata_i[BIT_STOP];
  assign cmd_wbit[CMD_NACK]  = wdata_i[BIT_NACK];

  assign cmd_done[CMD_START] = start_done_i;
  assign cmd_done[CMD_STOP]  = stop_done_i;
  assign cmd_done[CMD_NACK]  = nack_done_i;

  for (genvar g = 0; g < NUM_CMD; g++) begin : g_cmd
    if (MODE_GATED[g]) begin : g_gated
      assign cmd_set[g] = wr_en_i && cmd_wbit[g] && wr_master;
    end else begin : g_free
      assign cmd_set[g] = wr_en_i && cmd_wbit[g];
    end

    i2c_cmd_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (cmd_set[g]),
      .done_i (cmd_done[g]),
      .flush_i(srst_busy),
      .pend_o (cmd_pend[g])
    );
  end

  i2c_srst_seq #(.CYCLES(SRST_CYCLES)) u_srst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .kick_i(wr_en_i && wdata_i[BIT_SRST]),
    .busy_o(srst_busy)
  );

  always_comb begin
    rdata_o            = '0;
    rdata_o[BIT_EN]    = en_q;
    rdata_o[BIT_SRST]  = srst_busy;
    rdata_o[BIT_START] = cmd_pend[CMD_START];
    rdata_o[BIT_STOP]  = cmd_pend[CMD_STOP];
    rdata_o[BIT_NACK]  = cmd_pend[CMD_NACK];
    rdata_o[BIT_MODE]  = mode_q;
  end

  assign master_o    = mode_q;
  assign enable_o    = en_q;
  assign start_req_o = cmd_pend[CMD_START];
  assign stop_req_o  = cmd_pend[CMD_STOP];
  assign nack_req_o  = cmd_pend[CMD_NACK];
  assign srst_o      = srst_busy;
endmodule

// File: rtl/i2c_ctl_reg_chk.sv
module i2c_ctl_reg_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              master_o,
  input logic              enable_o,
  input logic              start_req_o,
  input logic              stop_req_o,
  input logic              nack_req_o,
  input logic              start_done_i,
  input logic              stop_done_i,
  input logic              nack_done_i,
  input logic              srst_o
);
  p_reserved_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:6] == '0);

  p_start_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_req_o && start_done_i && !srst_o && !(wr_en_i && wdata_i[2] && wdata_i[5])
    |=> !start_req_o);

  p_stop_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_req_o && stop_done_i && !srst_o && !(wr_en_i && wdata_i[3] && wdata_i[5])
    |=> !stop_req_o);

  p_slave_ignore_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wdata_i[5] && !start_req_o && !stop_req_o
    |=> !start_req_o && !stop_req_o);

  p_nack_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_req_o && nack_done_i && !srst_o && !(wr_en_i && wdata_i[4])
    |=> !nack_req_o);

  p_srst_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_o |=> !start_req_o && !stop_req_o && !nack_req_o);

  p_srst_keep_mode_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_o && !wr_en_i |=> $stable(master_o) && $stable(enable_o));

  p_idle_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_req_o && !wr_en_i |=> !start_req_o);

  p_write_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wdata_i[4] && nack_done_i && !srst_o |=> nack_req_o);

  p_req_mirror_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[4:2] == {nack_req_o, stop_req_o, start_req_o});
endmodule

bind i2c_ctl_reg i2c_ctl_reg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .master_o    (master_o),
  .enable_o    (enable_o),
  .start_req_o (start_req_o),
  .stop_req_o  (stop_req_o),
  .nack_req_o  (nack_req_o),
  .start_done_i(start_done_i),
  .stop_done_i (stop_done_i),
  .nack_done_i (nack_done_i),
  .srst_o      (srst_o)
);

// File: tb/i2c_ctl_reg_test.sv
`timescale 1ns/1ps
module i2c_ctl_reg_test;
  localparam int DW = 16;
  localparam int SC = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic sd = 1'b0, pd = 1'b0, nd = 1'b0;
  logic [DW-1:0] rdata;
  logic master, enable, start_req, stop_req, nack_req, srst;

  int n_vec = 0;
  int n_bad = 0;
  bit done_flag = 0;

  // reference state
  logic m_mode = 0, m_en = 0, m_start = 0, m_stop = 0, m_nack = 0, m_busy = 0;
  int   m_cnt = 0;

  always #2 clk = ~clk;

  i2c_ctl_reg #(.DATA_W(DW), .SRST_CYCLES(SC)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wdata_i(wdata),
    .rdata_o(rdata), .master_o(master), .enable_o(enable),
    .start_req_o(start_req), .stop_req_o(stop_req), .nack_req_o(nack_req),
    .start_done_i(sd), .stop_done_i(pd), .nack_done_i(nd), .srst_o(srst)
  );

  function automatic logic [DW-1:0] exp_rd();
    return {10'b0, m_mode, m_nack, m_stop, m_start, m_busy, m_en};
  endfunction

  task automatic check(input string tag);
    logic [DW-1:0] e;
    logic [5:0] eo, ao;
    e  = exp_rd();
    eo = {m_mode, m_en, m_start, m_stop, m_nack, m_busy};
    ao = {master, enable, start_req, stop_req, nack_req, srst};
    n_vec++;
    if (rdata !== e || ao !== eo) begin
      n_bad++;
      $display("FAIL %s rdata=%h outs=%b expected rdata=%h outs=%b", tag, rdata, ao, e, eo);
    end
  endtask

  task automatic step(input logic wr, input logic [DW-1:0] wd,
                      input logic s, input logic p, input logic n, input string tag);
    logic nm, ne, ns, np, nn, nb;
    int nc;
    @(negedge clk);
    wr_en = wr; wdata = wd; sd = s; pd = p; nd = n;
    nm = wr ? wd[5] : m_mode;
    ne = wr ? wd[0] : m_en;
    if (m_busy) begin
      ns = 0; np = 0; nn = 0;
    end else begin
      ns = (wr && wd[2] && wd[5]) ? 1'b1 : (s ? 1'b0 : m_start);
      np = (wr && wd[3] && wd[5]) ? 1'b1 : (p ? 1'b0 : m_stop);
      nn = (wr && wd[4])          ? 1'b1 : (n ? 1'b0 : m_nack);
    end
    nb = m_busy; nc = m_cnt;
    if (m_busy) begin
      if (m_cnt == SC - 1) begin nb = 0; nc = 0; end
      else nc = m_cnt + 1;
    end else if (wr && wd[1]) begin
      nb = 1; nc = 0;
    end
    @(posedge clk);
    m_mode = nm; m_en = ne; m_start = ns; m_stop = np; m_nack = nn;
    m_busy = nb; m_cnt = nc;
    #1 check(tag);
  endtask

  initial begin
    #400000;
    if (!done_flag) begin
      done_flag = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #11;
    check("R2");
    @(negedge clk) rst_ni = 1'b1;
    step(0, 16'h0000, 1, 1, 1, "R10");

    step(1, 16'hFFC0, 0, 0, 0, "R1");
    step(1, 16'h0021, 0, 0, 0, "R7");
    step(1, 16'h0024, 0, 0, 0, "R3");
    step(0, 16'h0000, 0, 0, 0, "R3");
    step(0, 16'h0000, 0, 1, 1, "R10");
    step(0, 16'h0000, 1, 0, 0, "R3");
    step(1, 16'h0028, 0, 0, 0, "R4");
    step(1, 16'h0020, 0, 0, 0, "R7");
    step(0, 16'h0000, 0, 0, 0, "R4");
    step(0, 16'h0000, 0, 1, 0, "R4");
    step(1, 16'h001D, 0, 0, 0, "R5");
    step(0, 16'h0000, 0, 0, 0, "R6");
    step(0, 16'h0000, 0, 0, 1, "R6");
    step(1, 16'h0030, 0, 0, 1, "R11");
    step(1, 16'h0024, 1, 0, 0, "R11");
    step(1, 16'h003F, 0, 0, 0, "R8");
    step(1, 16'h0036, 0, 0, 0, "R9");
    step(1, 16'h0022, 0, 0, 0, "R8");
    step(0, 16'h0000, 0, 0, 0, "R8");
    step(0, 16'h0000, 0, 0, 0, "R8");
    step(0, 16'h0000, 0, 0, 0, "R9");
    step(0, 16'h0000, 0, 0, 0, "R12");

    // sweep: low six bits x done patterns x reserved fill
    for (int i = 0; i < 1024; i++) begin
      logic [DW-1:0] wd;
      wd = {{10{i[9]}}, i[5:0]};
      step(1, wd, i[6], i[7], i[8], "R12");
      step(i[0] ^ i[3], {10'b0, i[3:0], i[5:4]}, i[7], i[8], i[6], "R9");
      step(0, 16'h0000, i[8], i[6], i[7], "R10");
    end
    for (int k = 0; k < SC + 2; k++) step(0, 16'h0000, 1, 1, 1, "R8");

    rst_ni = 1'b0;
    #1;
    m_mode = 0; m_en = 0; m_start = 0; m_stop = 0; m_nack = 0; m_busy = 0; m_cnt = 0;
    check("R2");

    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule